// File: doc/BRIEF.md
# Tagged Floating-Point Register File

This block holds the architectural floating-point registers of an out-of-order core. Each register carries a value and a producer tag. A zero tag means the value is final. A non-zero tag names the station that will deliver the value later. An issuing instruction reads two sources through combinational ports. Each port returns either a usable value (tag zero) or the tag to wait for. In the same cycle the instruction can claim its destination by writing its own station tag into that register.

Results do not arrive by address. A single result broadcast carries a source tag with the data. Every register whose recorded tag equals the broadcast tag takes the data and becomes ready. A later claim on a register simply replaces an older pending tag, so an older result that arrives afterwards is dropped. This is how output dependencies on register names go away.

A read that coincides with a matching broadcast is forwarded the broadcast data directly. A claim that coincides with a matching broadcast to the same register keeps the new tag.

Top module: `rtag_regfile`

## Requirements
- R1: A clock edge with `rst_n` low clears every register to value 0 and tag 0. Reads after reset return value 0 and tag 0 for all 16 registers.
- R2: When a register has tag 0 and no broadcast is pending for it, a source port returns its value and tag 0. When its tag is non-zero, the port returns that tag.
- R3: A claim (`rn_en`=1, `rn_tag`≠0) to register `rn_idx` makes reads of that register return `rn_tag` from the next cycle on, until the register is captured or claimed again.
- R4: A broadcast (`bc_valid`=1, `bc_tag`≠0) writes `bc_data` into every register whose tag equals `bc_tag`. From the next cycle on, those registers read back with that data and tag 0.
- R5: Registers whose tag differs from `bc_tag`, including ready registers with tag 0, keep their value and tag through a broadcast.
- R6: A broadcast with `bc_valid`=0, or with `bc_tag`=0, changes no register.
- R7: A claim on a register that is already pending replaces the older tag. A later broadcast of the older tag leaves that register pending under the newer tag.
- R8: When a claim and a matching broadcast hit the same register in one cycle, the register takes the claimed tag, keeps its old value, and stays pending.
- R9: When a source port reads a register whose tag equals the tag of a valid broadcast with non-zero tag in the same cycle, the port returns `bc_data` and tag 0.
- R10: A claim with `rn_tag`=0 has no effect on the register file.
- R11: Source reads in the cycle of a claim return the state before that claim, so an instruction may name the same register as both source and destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_idx | input | 4 | Source port A register index |
| rd_a_val | output | 64 | Source port A value, meaningful when `rd_a_tag` is 0 |
| rd_a_tag | output | 4 | Source port A producer tag, 0 when ready |
| rd_b_idx | input | 4 | Source port B register index |
| rd_b_val | output | 64 | Source port B value, meaningful when `rd_b_tag` is 0 |
| rd_b_tag | output | 4 | Source port B producer tag, 0 when ready |
| rn_en | input | 1 | Destination claim enable |
| rn_idx | input | 4 | Destination register index |
| rn_tag | input | 4 | Station tag that will produce the destination |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | 4 | Tag of the station producing the broadcast result |
| bc_data | input | 64 | Broadcast result data |

## Verification
The source ports are combinational, so the effect of a forwarded broadcast is due in the same cycle as the stimulus. Captures and claims are due one cycle later, after the single register stage. Each driver step records the expected read results together with the index of the cycle they belong to. The monitor compares them mid-cycle in that same cycle index, away from both the edge that updates the state and the point where the inputs change. A reference model in the bench is advanced at each edge from the requirement rules, so the expected values for the next step already include captures, claims and the priority between them.

// File: rtl/rtf_pkg.sv
// Package rtf_pkg
// Shared types for the tagged register file. Holds the per-slot update
// action chosen each cycle. Assumes nothing beyond 1800-2017 packages.
package rtf_pkg;

    // Update chosen for one register slot at the next clock edge
    typedef enum logic [1:0] {
        SLOT_HOLD    = 2'd0,
        SLOT_CLAIM   = 2'd1,
        SLOT_CAPTURE = 2'd2
    } slot_act_e;

endpackage

// File: rtl/rtf_slot.sv
// Module rtf_slot
// One register of the file: a data value and its producer tag.
// A claim replaces the tag and has priority over a capture. A capture
// takes the broadcast data when the stored tag equals the broadcast tag.
// Assumes: claim_hit is already qualified with a non-zero tag, and
// bc_fire is already qualified with a non-zero broadcast tag.
module rtf_slot
    import rtf_pkg::*;
#(
    parameter int DW = 64,
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          claim_hit,
    input  logic [TW-1:0] claim_tag,
    input  logic          bc_fire,
    input  logic [TW-1:0] bc_tag,
    input  logic [DW-1:0] bc_data,
    output logic [DW-1:0] val_q,
    output logic [TW-1:0] tag_q
);

    slot_act_e act;

    // Pick this cycle's update, claim first
    always_comb begin
        act = SLOT_HOLD;
        if (claim_hit) begin
            act = SLOT_CLAIM;
        end else if (bc_fire && (tag_q == bc_tag)) begin
            act = SLOT_CAPTURE;
        end
    end

    // Apply the chosen update, or clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            tag_q <= '0;
        end else begin
            case (act)
                SLOT_CLAIM: begin
                    tag_q <= claim_tag;
                end
                SLOT_CAPTURE: begin
                    val_q <= bc_data;
                    tag_q <= '0;
                end
                default: begin
                    val_q <= val_q;
                    tag_q <= tag_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/rtf_read_port.sv
// Module rtf_read_port
// Combinational source-operand port. It selects one register from the
// flattened value and tag vectors. When a qualified broadcast carries the
// tag that the selected register waits on, it forwards the broadcast data
// with tag zero. Assumes bc_fire already excludes tag zero.
module rtf_read_port #(
    parameter int NREG = 16,
    parameter int DW   = 64,
    parameter int TW   = 4,
    parameter int AW   = $clog2(NREG)
) (
    input  logic [AW-1:0]      idx,
    input  logic [NREG*DW-1:0] val_flat,
    input  logic [NREG*TW-1:0] tag_flat,
    input  logic               bc_fire,
    input  logic [TW-1:0]      bc_tag,
    input  logic [DW-1:0]      bc_data,
    output logic [DW-1:0]      val,
    output logic [TW-1:0]      tag
);

    logic [DW-1:0] held_val;
    logic [TW-1:0] held_tag;
    logic          fwd;

    // Select the addressed register
    always_comb begin
        held_val = val_flat[idx*DW +: DW];
        held_tag = tag_flat[idx*TW +: TW];
    end

    // Forward a matching broadcast, else pass the stored state
    always_comb begin
        fwd = bc_fire && (held_tag == bc_tag);
        if (fwd) begin
            val = bc_data;
            tag = '0;
        end else begin
            val = held_val;
            tag = held_tag;
        end
    end

endmodule

// File: rtl/rtag_regfile.sv
// Module rtag_regfile
// Floating-point register file with per-register producer tags. It has two
// combinational source ports, one destination claim port and one result
// broadcast input. Values arrive by tag match, not by address.
// Assumes: tag 0 is reserved for "ready", and station tags are non-zero.
// Reset is synchronous and active low.
module rtag_regfile #(
    parameter int NREG = 16,
    parameter int DW   = 64,
    parameter int TW   = 4,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_idx,
    output logic [DW-1:0] rd_a_val,
    output logic [TW-1:0] rd_a_tag,
    input  logic [AW-1:0] rd_b_idx,
    output logic [DW-1:0] rd_b_val,
    output logic [TW-1:0] rd_b_tag,
    input  logic          rn_en,
    input  logic [AW-1:0] rn_idx,
    input  logic [TW-1:0] rn_tag,
    input  logic          bc_valid,
    input  logic [TW-1:0] bc_tag,
    input  logic [DW-1:0] bc_data
);

    logic               rn_fire;
    logic               bc_fire;
    logic [NREG*DW-1:0] val_flat;
    logic [NREG*TW-1:0] tag_flat;

    // Qualify claims and broadcasts: tag zero never acts
    always_comb begin
        rn_fire = rn_en && (rn_tag != '0);
        bc_fire = bc_valid && (bc_tag != '0);
    end

    // One slot per register, each decoding its own claim
    for (genvar i = 0; i < NREG; i++) begin : g_slot
        logic claim_hit;

        // Claim decode for this slot
        always_comb claim_hit = rn_fire && (rn_idx == AW'(i));

        rtf_slot #(
            .DW (DW),
            .TW (TW)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .claim_hit (claim_hit),
            .claim_tag (rn_tag),
            .bc_fire   (bc_fire),
            .bc_tag    (bc_tag),
            .bc_data   (bc_data),
            .val_q     (val_flat[i*DW +: DW]),
            .tag_q     (tag_flat[i*TW +: TW])
        );
    end

    rtf_read_port #(
        .NREG (NREG),
        .DW   (DW),
        .TW   (TW),
        .AW   (AW)
    ) u_port_a (
        .idx      (rd_a_idx),
        .val_flat (val_flat),
        .tag_flat (tag_flat),
        .bc_fire  (bc_fire),
        .bc_tag   (bc_tag),
        .bc_data  (bc_data),
        .val      (rd_a_val),
        .tag      (rd_a_tag)
    );

    rtf_read_port #(
        .NREG (NREG),
        .DW   (DW),
        .TW   (TW),
        .AW   (AW)
    ) u_port_b (
        .idx      (rd_b_idx),
        .val_flat (val_flat),
        .tag_flat (tag_flat),
        .bc_fire  (bc_fire),
        .bc_tag   (bc_tag),
        .bc_data  (bc_data),
        .val      (rd_b_val),
        .tag      (rd_b_tag)
    );

endmodule

// File: rtl/rtf_checker.sv
// Module rtf_checker
// Property checks for rtag_regfile, observed through source port A and the
// stored tag vector. It is attached with the bind statement at the end of
// this file. Assumes the bench holds rst_n low at the first clock edge.
module rtf_checker #(
    parameter int NREG = 16,
    parameter int DW   = 64,
    parameter int TW   = 4,
    localparam int AW  = $clog2(NREG)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [AW-1:0]      rd_a_idx,
    input logic [DW-1:0]      rd_a_val,
    input logic [TW-1:0]      rd_a_tag,
    input logic               rn_en,
    input logic [AW-1:0]      rn_idx,
    input logic [TW-1:0]      rn_tag,
    input logic               bc_valid,
    input logic [TW-1:0]      bc_tag,
    input logic [DW-1:0]      bc_data,
    input logic [NREG*TW-1:0] tag_flat
);

    function automatic logic [TW-1:0] tag_at(input logic [AW-1:0] i);
        return tag_flat[i*TW +: TW];
    endfunction

    logic claim_ok;
    logic bcast_ok;
    logic cap_a;

    // Observer-side qualification of claims, broadcasts and port A captures
    always_comb begin
        claim_ok = rn_en && (rn_tag != '0);
        bcast_ok = bc_valid && (bc_tag != '0);
        cap_a    = bcast_ok && (tag_at(rd_a_idx) == bc_tag)
                   && !(claim_ok && (rn_idx == rd_a_idx));
    end

    // R1: the first cycle out of reset reads tag zero
    a_r1_reset_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rd_a_tag == '0));

    // R3: a claimed register reads its new tag one cycle later
    a_r3_claim_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_ok && $past(rst_n) && !$past(rst_n) == 1'b0) |=>
        ((rd_a_idx != $past(rn_idx)) || (bc_valid && bc_tag == $past(rn_tag))
         || (rd_a_tag == $past(rn_tag))));

    // R4: a captured register reads the broadcast data with tag zero
    a_r4_capture_data: assert property (@(posedge clk) disable iff (!rst_n)
        cap_a |=> ((rd_a_idx != $past(rd_a_idx))
                   || (rd_a_tag == '0 && rd_a_val == $past(bc_data))));

    // R6: without a broadcast or a claim, no stored tag moves
    a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!bc_valid && !claim_ok) |=> $stable(tag_flat));

    // R8: a claim beats a same-cycle matching broadcast
    a_r8_claim_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_ok && bcast_ok && tag_at(rn_idx) == bc_tag) |=>
        (tag_at($past(rn_idx)) == $past(rn_tag)));

    // R9: a read that meets its producer's broadcast is forwarded
    a_r9_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast_ok && tag_at(rd_a_idx) == bc_tag) |->
        (rd_a_tag == '0 && rd_a_val == bc_data));

endmodule

bind rtag_regfile rtf_checker #(
    .NREG (NREG),
    .DW   (DW),
    .TW   (TW)
) u_rtf_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (rd_a_idx),
    .rd_a_val (rd_a_val),
    .rd_a_tag (rd_a_tag),
    .rn_en    (rn_en),
    .rn_idx   (rn_idx),
    .rn_tag   (rn_tag),
    .bc_valid (bc_valid),
    .bc_tag   (bc_tag),
    .bc_data  (bc_data),
    .tag_flat (tag_flat)
);

// File: tb/rtag_regfile_tb_top.sv
`timescale 1ns/100ps
// Bench for rtag_regfile: a driver task records expected read results in a
// queue, and a mid-cycle monitor pops and compares them.
module rtag_regfile_tb_top;

    localparam int NREG = 16;
    localparam int DW   = 64;
    localparam int TW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    rd_a_idx = '0;
    logic [DW-1:0] rd_a_val;
    logic [TW-1:0] rd_a_tag;
    logic [3:0]    rd_b_idx = '0;
    logic [DW-1:0] rd_b_val;
    logic [TW-1:0] rd_b_tag;
    logic          rn_en = 1'b0;
    logic [3:0]    rn_idx = '0;
    logic [TW-1:0] rn_tag = '0;
    logic          bc_valid = 1'b0;
    logic [TW-1:0] bc_tag = '0;
    logic [DW-1:0] bc_data = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    typedef struct {
        int            cyc;
        bit            port_b;
        logic [3:0]    idx;
        logic [DW-1:0] val;
        logic [TW-1:0] tag;
        string         req;
    } exp_t;

    exp_t sb[$];

    // Reference state, advanced from the requirement rules
    logic [DW-1:0] m_val [NREG];
    logic [TW-1:0] m_tag [NREG];

    rtag_regfile dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (rd_a_idx),
        .rd_a_val (rd_a_val),
        .rd_a_tag (rd_a_tag),
        .rd_b_idx (rd_b_idx),
        .rd_b_val (rd_b_val),
        .rd_b_tag (rd_b_tag),
        .rn_en    (rn_en),
        .rn_idx   (rn_idx),
        .rn_tag   (rn_tag),
        .bc_valid (bc_valid),
        .bc_tag   (bc_tag),
        .bc_data  (bc_data)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every expectation due in this cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t e;
            logic [DW-1:0] av;
            logic [TW-1:0] at;
            bit bad;
            e  = sb.pop_front();
            av = e.port_b ? rd_b_val : rd_a_val;
            at = e.port_b ? rd_b_tag : rd_a_tag;
            n_cmp++;
            bad = (e.cyc != cyc) || (at !== e.tag)
                  || ((e.tag == '0) && (av !== e.val));
            if (bad) begin
                n_bad++;
                $display("FAIL %s port %s reg %0d: got val=%h tag=%0d, expected val=%h tag=%0d",
                         e.req, e.port_b ? "B" : "A", e.idx, av, at, e.val, e.tag);
            end
        end
    end

    function automatic void push_read(bit pb, logic [3:0] idx, string req);
        exp_t e;
        e.cyc    = cyc;
        e.port_b = pb;
        e.idx    = idx;
        e.req    = req;
        if (bc_valid && bc_tag != '0 && m_tag[idx] == bc_tag) begin
            e.val = bc_data;        // R9 forwarding
            e.tag = '0;
        end else begin
            e.val = m_val[idx];
            e.tag = m_tag[idx];
        end
        sb.push_back(e);
    endfunction

    // Driver: one cycle of stimulus, expectations, then model update
    task automatic step(input logic [3:0] ai, input logic [3:0] bi, input bit chk,
                        input bit rne, input logic [3:0] rni, input logic [TW-1:0] rnt,
                        input bit bcv, input logic [TW-1:0] bct, input logic [DW-1:0] bcd,
                        input string req);
        rd_a_idx = ai;
        rd_b_idx = bi;
        rn_en    = rne;
        rn_idx   = rni;
        rn_tag   = rnt;
        bc_valid = bcv;
        bc_tag   = bct;
        bc_data  = bcd;
        if (chk) begin
            push_read(1'b0, ai, req);
            push_read(1'b1, bi, req);
        end
        @(posedge clk);
        for (int i = 0; i < NREG; i++) begin
            if (rne && rnt != '0 && rni == 4'(i)) begin
                m_tag[i] = rnt;                     // R3, R7, R8, R10
            end else if (bcv && bct != '0 && m_tag[i] == bct) begin
                m_val[i] = bcd;                     // R4, R5, R6
                m_tag[i] = '0;
            end
        end
        #1;
    endtask

    task automatic rd(input logic [3:0] ai, input logic [3:0] bi, input string req);
        step(ai, bi, 1'b1, 1'b0, 4'd0, 4'd0, 1'b0, 4'd0, '0, req);
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        rn_en    = 1'b0;
        bc_valid = 1'b0;
        @(posedge clk);
        for (int i = 0; i < NREG; i++) begin
            m_val[i] = '0;
            m_tag[i] = '0;
        end
        #1;
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no completion, expected completion within 200000 cycles");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin
            m_val[i] = '0;
            m_tag[i] = '0;
        end
        #1;
        do_reset();
        @(posedge clk);
        #1;

        // R1: every register ready with zero value after reset
        for (int i = 0; i < NREG; i += 2) rd(4'(i), 4'(i + 1), "R1");

        // R11: read r2 while claiming r2 returns the old state; R3 afterwards
        step(4'd2, 4'd5, 1'b1, 1'b1, 4'd2, 4'd3, 1'b0, 4'd0, '0, "R11");
        step(4'd2, 4'd5, 1'b1, 1'b1, 4'd5, 4'd3, 1'b0, 4'd0, '0, "R3");
        rd(4'd2, 4'd5, "R3");

        // R4: one broadcast fills both registers waiting on tag 3
        step(4'd7, 4'd0, 1'b1, 1'b0, 4'd0, 4'd0, 1'b1, 4'd3, 64'hA5A5_0000_1111_2222, "R5");
        rd(4'd2, 4'd5, "R4");

        // R9 and R5: forward to a pending read, leave a ready register alone
        step(4'd1, 4'd9, 1'b1, 1'b1, 4'd9, 4'd5, 1'b0, 4'd0, '0, "R3");
        step(4'd9, 4'd1, 1'b1, 1'b0, 4'd0, 4'd0, 1'b1, 4'd5, 64'h0123_4567_89AB_CDEF, "R9");
        rd(4'd9, 4'd1, "R5");

        // R6: invalid broadcast and zero-tag broadcast change nothing
        step(4'd4, 4'd0, 1'b0, 1'b1, 4'd4, 4'd6, 1'b0, 4'd0, '0, "R3");
        step(4'd4, 4'd0, 1'b1, 1'b0, 4'd0, 4'd0, 1'b0, 4'd6, 64'hDEAD_BEEF_0000_0001, "R6");
        rd(4'd4, 4'd0, "R6");
        step(4'd0, 4'd2, 1'b0, 1'b0, 4'd0, 4'd0, 1'b1, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
        rd(4'd0, 4'd2, "R6");

        // R7: later claim replaces a pending tag; the old result is dropped
        step(4'd4, 4'd4, 1'b1, 1'b1, 4'd4, 4'd7, 1'b0, 4'd0, '0, "R7");
        step(4'd3, 4'd3, 1'b0, 1'b0, 4'd0, 4'd0, 1'b1, 4'd6, 64'h6666_6666_6666_6666, "R7");
        rd(4'd4, 4'd3, "R7");
        step(4'd0, 4'd0, 1'b0, 1'b0, 4'd0, 4'd0, 1'b1, 4'd7, 64'h7777_0000_7777_0000, "R7");
        rd(4'd4, 4'd4, "R7");

        // R8: claim and matching broadcast in one cycle, the claim wins
        step(4'd10, 4'd10, 1'b0, 1'b1, 4'd10, 4'd8, 1'b0, 4'd0, '0, "R3");
        step(4'd10, 4'd6, 1'b1, 1'b1, 4'd10, 4'd9, 1'b1, 4'd8, 64'h8888_8888_0000_0000, "R8");
        rd(4'd10, 4'd6, "R8");
        step(4'd0, 4'd0, 1'b0, 1'b0, 4'd0, 4'd0, 1'b1, 4'd9, 64'h9999_0000_0000_9999, "R8");
        rd(4'd10, 4'd10, "R8");

        // R10: a claim with tag zero leaves a pending register as it was
        step(4'd11, 4'd11, 1'b0, 1'b1, 4'd11, 4'd10, 1'b0, 4'd0, '0, "R3");
        step(4'd11, 4'd11, 1'b1, 1'b1, 4'd11, 4'd0, 1'b0, 4'd0, '0, "R10");
        rd(4'd11, 4'd12, "R10");

        // R2/R4/R9 mixed traffic with few tags so matches are frequent
        for (int k = 0; k < 300; k++) begin
            step(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)), 1'b1,
                 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)),
                 4'($urandom_range(0, 4)), 1'($urandom_range(0, 1)),
                 4'($urandom_range(0, 4)), {$urandom, $urandom}, "R2 mixed");
        end

        // R1: reset while registers are pending clears all of them
        do_reset();
        for (int i = 0; i < NREG; i += 2) rd(4'(i), 4'(i + 1), "R1");

        repeat (2) @(posedge clk);
        #1;
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: got %0d items left, expected 0", sb.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule